// File: doc/BRIEF.md
# Cascadable Parallel-to-Serial Serializer

This block turns a parallel word into a serial bit stream, least significant bit first. It runs in one of two modes. In single-rate mode it sends one bit per fast-clock cycle. In double-rate mode it sends two bits per fast-clock cycle: `serOut[0]` carries the bit for the earlier edge and `serOut[1]` the bit for the later edge. A one-cycle load strobe, asserted once per word period, marks the edge of the divided clock. On that strobe the unit captures its six data inputs. Between strobes it shifts the captured word toward the output.

A single unit handles words of up to six bits. Wider words need two identical units. One is configured as master and the other as slave, and both get the same mode and width. The slave's two shift-out lines feed the master's two shift-in lines. The slave loads only its inputs 3 to 6 (`dataIn[5:2]`) and passes those bits up the chain. The master emits them after its own six bits. The slave's serial output stays low. A width that the selected mode does not allow raises a configuration error and holds the output low.

Top module: `ser_unit`

## Requirements
- R1: With `ddrMode`=0, widths 2 to 8 are legal. Word bit k appears on `serOut[0]` in the k-th fast cycle after the load edge (k = 0 is the first cycle after that edge), and `serOut[1]` is 0.
- R2: With `ddrMode`=1, widths 4, 6, 8 and 10 are legal. In the p-th cycle after the load edge, `serOut[0]` carries word bit 2p and `serOut[1]` carries word bit 2p+1.
- R3: A high `loadStb` at a clock edge captures `dataIn` and overrides shifting at that edge. When the strobe repeats every width cycles (single-rate) or every width/2 cycles (double-rate), consecutive words come out back to back.
- R4: In a cascade, word bits 0 to 5 enter the master's `dataIn[5:0]` and bits 6 and up enter the slave's `dataIn[5:2]` in ascending order. The master emits the whole word, and the slave's `serOut` stays 0.
- R5: A slave (`isSlave`=1) ignores `dataIn[1:0]`. Their values never reach the master's stream.
- R6: At width 7 the stream uses slave input 3, at width 8 inputs 3 and 4, and at double-rate width 10 inputs 3 to 6. The extra bits come out right after master bit 5.
- R7: A width that is not legal for the selected mode drives `cfgErr` high and holds `serOut` at 0. A legal width keeps `cfgErr` low.
- R8: A synchronous reset clears the shift register, so `serOut` and `shiftOut` read 0 after the reset edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast serial clock |
| rst | input | 1 | Synchronous reset, active high |
| loadStb | input | 1 | One-cycle word-load strobe (divided-clock edge) |
| isSlave | input | 1 | 1 = slave unit of a cascade, 0 = master |
| ddrMode | input | 1 | 1 = two bits per cycle, 0 = one bit per cycle |
| width | input | 4 | Word width in bits |
| dataIn | input | 6 | Parallel data inputs 1 to 6 (bit 0 = input 1) |
| shiftIn | input | 2 | Cascade chain in, from the slave's `shiftOut` |
| shiftOut | output | 2 | Cascade chain out, to the master's `shiftIn` |
| serOut | output | 2 | Serial data; bit 0 is the earlier bit |
| cfgErr | output | 1 | Illegal width for the selected mode |

## Verification
On every cycle, assertions in the datapath check the register-level rules. At most one strobe is active at a time. A load captures the inputs, with the slave's two low bits cleared. A single or double shift moves the register down by one or two places. The register reads zero when reset ends. End-to-end properties can only be shown by the bench's scenarios. These are the bit order across a two-unit cascade at every legal width in both modes, the slave's low inputs being ignored, and the output held low under an illegal configuration. The bench recovers the serial stream and compares it with the expected order.

// File: rtl/ser_pkg.sv
`timescale 1ns/1ps
package ser_pkg;
  // Strobes from the control decode to the shift datapath
  typedef struct packed {
    logic load;      // capture parallel inputs
    logic shiftOne;  // single-rate shift by one place
    logic shiftTwo;  // double-rate shift by two places
  } ser_strobe_t;
endpackage

// File: rtl/ser_ctrl.sv
`timescale 1ns/1ps
module ser_ctrl
  import ser_pkg::*;
#(
  parameter int WIDTH_BITS  = 4,
  parameter int UNIT_INPUTS = 6,
  parameter int CHAIN_W     = 2,
  parameter int SDR_MIN     = 2,
  parameter int DDR_MIN     = 4
) (
  input  logic                  loadStb,
  input  logic                  ddrMode,
  input  logic [WIDTH_BITS-1:0] width,
  output ser_strobe_t           strb,
  output logic                  cfgErr
);
  localparam int SLAVE_USED = UNIT_INPUTS - CHAIN_W;
  localparam int SDR_MAX    = UNIT_INPUTS + CHAIN_W;
  localparam int DDR_MAX    = UNIT_INPUTS + SLAVE_USED;

  logic sdrOk;
  logic ddrOk;

  always_comb begin
    sdrOk  = (width >= WIDTH_BITS'(SDR_MIN)) && (width <= WIDTH_BITS'(SDR_MAX));
    ddrOk  = !width[0] && (width >= WIDTH_BITS'(DDR_MIN)) && (width <= WIDTH_BITS'(DDR_MAX));
    cfgErr = ddrMode ? !ddrOk : !sdrOk;
    strb.load     = loadStb && !cfgErr;
    strb.shiftOne = !loadStb && !ddrMode && !cfgErr;
    strb.shiftTwo = !loadStb && ddrMode && !cfgErr;
  end
endmodule

// File: rtl/ser_shift.sv
`timescale 1ns/1ps
module ser_shift
  import ser_pkg::*;
#(
  parameter int UNIT_INPUTS = 6,
  parameter int CHAIN_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  ser_strobe_t            strb,
  input  logic                   isSlave,
  input  logic [UNIT_INPUTS-1:0] dataIn,
  input  logic [CHAIN_W-1:0]     shiftIn,
  output logic [CHAIN_W-1:0]     headBits,
  output logic [CHAIN_W-1:0]     shiftOut
);
  logic [UNIT_INPUTS-1:0] shReg;
  logic [UNIT_INPUTS-1:0] loadVal;

  // Slave drops its lowest CHAIN_W inputs; those places never reach the chain
  for (genvar i = 0; i < UNIT_INPUTS; i++) begin : g_load
    if (i < CHAIN_W) begin : g_mask
      assign loadVal[i] = dataIn[i] & ~isSlave;
    end else begin : g_pass
      assign loadVal[i] = dataIn[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      shReg <= '0;
    end else if (strb.load) begin
      shReg <= loadVal;
    end else if (strb.shiftOne) begin
      shReg <= {shiftIn[0], shReg[UNIT_INPUTS-1:1]};
    end else if (strb.shiftTwo) begin
      shReg <= {shiftIn[1], shiftIn[0], shReg[UNIT_INPUTS-1:2]};
    end
  end

  assign headBits = shReg[CHAIN_W-1:0];
  assign shiftOut = shReg[2*CHAIN_W-1:CHAIN_W];

  // R1 R2
  strobe_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.load, strb.shiftOne, strb.shiftTwo}));

  // R8
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (shReg == '0));

  // R3
  load_upper_chk: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> (shReg[UNIT_INPUTS-1:CHAIN_W] == $past(dataIn[UNIT_INPUTS-1:CHAIN_W])));

  // R5
  slave_low_chk: assert property (@(posedge clk) disable iff (rst)
    (strb.load && isSlave) |=> (shReg[CHAIN_W-1:0] == '0));

  // R1
  shift_one_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftOne |=> (shReg[UNIT_INPUTS-2:0] == $past(shReg[UNIT_INPUTS-1:1])));

  // R2
  shift_two_chk: assert property (@(posedge clk) disable iff (rst)
    strb.shiftTwo |=> (shReg[UNIT_INPUTS-3:0] == $past(shReg[UNIT_INPUTS-1:2])));
endmodule

// File: rtl/ser_unit.sv
`timescale 1ns/1ps
module ser_unit
  import ser_pkg::*;
#(
  parameter int WIDTH_BITS  = 4,
  parameter int UNIT_INPUTS = 6,
  parameter int CHAIN_W     = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   loadStb,
  input  logic                   isSlave,
  input  logic                   ddrMode,
  input  logic [WIDTH_BITS-1:0]  width,
  input  logic [UNIT_INPUTS-1:0] dataIn,
  input  logic [CHAIN_W-1:0]     shiftIn,
  output logic [CHAIN_W-1:0]     shiftOut,
  output logic [CHAIN_W-1:0]     serOut,
  output logic                   cfgErr
);
  ser_strobe_t        strb;
  logic [CHAIN_W-1:0] headBits;

  ser_ctrl #(
    .WIDTH_BITS (WIDTH_BITS),
    .UNIT_INPUTS(UNIT_INPUTS),
    .CHAIN_W    (CHAIN_W),
    .SDR_MIN    (2),
    .DDR_MIN    (4)
  ) u_ctrl (
    .loadStb(loadStb),
    .ddrMode(ddrMode),
    .width  (width),
    .strb   (strb),
    .cfgErr (cfgErr)
  );

  ser_shift #(
    .UNIT_INPUTS(UNIT_INPUTS),
    .CHAIN_W    (CHAIN_W)
  ) u_shift (
    .clk     (clk),
    .rst     (rst),
    .strb    (strb),
    .isSlave (isSlave),
    .dataIn  (dataIn),
    .shiftIn (shiftIn),
    .headBits(headBits),
    .shiftOut(shiftOut)
  );

  // Only a healthy master drives the line; single-rate uses the earlier lane
  always_comb begin
    if (cfgErr || isSlave) serOut = '0;
    else if (ddrMode)      serOut = headBits;
    else                   serOut = {{(CHAIN_W-1){1'b0}}, headBits[0]};
  end
endmodule

// File: tb/ser_unit_tb.sv
`timescale 1ns/1ps
module ser_unit_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       mLoad = 1'b0;
  logic       sLoad = 1'b0;
  logic       cfgDdr = 1'b0;
  logic [3:0] cfgWidth = 4'd8;
  logic [5:0] mData = '0;
  logic [5:0] sData = '0;
  logic [1:0] chain;
  logic [1:0] mShiftOut;
  logic [1:0] mSer;
  logic [1:0] sSer;
  logic       mErr;
  logic       sErr;
  int         checks = 0;
  int         failures = 0;

  always #2.5 clk = ~clk;

  ser_unit u_dut (
    .clk(clk), .rst(rst), .loadStb(mLoad), .isSlave(1'b0), .ddrMode(cfgDdr),
    .width(cfgWidth), .dataIn(mData), .shiftIn(chain), .shiftOut(mShiftOut),
    .serOut(mSer), .cfgErr(mErr)
  );

  ser_unit u_slave (
    .clk(clk), .rst(rst), .loadStb(sLoad), .isSlave(1'b1), .ddrMode(cfgDdr),
    .width(cfgWidth), .dataIn(sData), .shiftIn(2'b00), .shiftOut(chain),
    .serOut(sSer), .cfgErr(sErr)
  );

  task automatic check(input bit ok, input string tag, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Stream nWords random words through the cascade and compare every cycle
  task automatic runStream(input bit ddr, input int w, input string tag, input bit lowOnes);
    logic [9:0] words [8];
    int per;
    int total;
    per = ddr ? w / 2 : w;
    total = 8 * per;
    @(negedge clk);
    cfgDdr = ddr;
    cfgWidth = 4'(w);
    for (int i = 0; i < 8; i++) words[i] = 10'($urandom) & 10'((1 << w) - 1);
    for (int c = 0; c <= total; c++) begin
      @(negedge clk);
      if (c > 0) begin
        int wi;
        int p;
        logic [1:0] exp;
        wi = (c - 1) / per;
        p = (c - 1) % per;
        exp = ddr ? {words[wi][2*p+1], words[wi][2*p]} : {1'b0, words[wi][p]};
        check(mSer == exp, tag, 16'(mSer), 16'(exp));
        check(sSer == 2'b00, "R4 slave line", 16'(sSer), 16'h0);
        if (c == 1) check(mErr == 1'b0, "R7 legal", 16'(mErr), 16'h0);
      end
      if (c < total && (c % per) == 0) begin
        mData = words[c / per][5:0];
        sData = {words[c / per][9:6], lowOnes ? 2'b11 : 2'($urandom)};
        mLoad = 1'b1;
        sLoad = 1'b1;
      end else begin
        mLoad = 1'b0;
        sLoad = 1'b0;
      end
    end
  endtask

  // R7: illegal widths raise the flag and keep the line low
  task automatic illegalCfg(input bit ddr, input int w);
    @(negedge clk);
    cfgDdr = ddr;
    cfgWidth = 4'(w);
    mData = 6'h3F;
    sData = 6'h3F;
    mLoad = 1'b1;
    sLoad = 1'b1;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      mLoad = 1'b0;
      sLoad = 1'b0;
      check(mErr == 1'b1, "R7 flag", 16'(mErr), 16'h1);
      check(mSer == 2'b00, "R7 line low", 16'(mSer), 16'h0);
    end
  endtask

  // R8: reset in the middle of a word clears the register
  task automatic midReset();
    @(negedge clk);
    cfgDdr = 1'b0;
    cfgWidth = 4'd6;
    mData = 6'h3F;
    mLoad = 1'b1;
    @(negedge clk);
    mLoad = 1'b0;
    check(mSer == 2'b01, "R3 loaded bit0", 16'(mSer), 16'h1);
    rst = 1'b1;
    @(negedge clk);
    check(mSer == 2'b00, "R8 line after reset", 16'(mSer), 16'h0);
    check(mShiftOut == 2'b00, "R8 chain after reset", 16'(mShiftOut), 16'h0);
    rst = 1'b0;
  endtask

  initial begin
    #1000000;
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(mSer == 2'b00, "R8 reset line", 16'(mSer), 16'h0);
    check(chain == 2'b00, "R8 reset chain", 16'(chain), 16'h0);
    rst = 1'b0;
    for (int w = 2; w <= 6; w++) runStream(1'b0, w, "R1 sdr single", 1'b0);
    runStream(1'b0, 7, "R6 sdr width7 cascade", 1'b0);
    runStream(1'b0, 8, "R4 sdr width8 cascade", 1'b0);
    runStream(1'b1, 4, "R2 ddr width4", 1'b0);
    runStream(1'b1, 6, "R2 ddr width6", 1'b0);
    runStream(1'b1, 8, "R6 ddr width8 cascade", 1'b0);
    runStream(1'b1, 10, "R6 ddr width10 cascade", 1'b0);
    runStream(1'b0, 8, "R5 slave low inputs high", 1'b1);
    runStream(1'b1, 10, "R5 slave low inputs high ddr", 1'b1);
    runStream(1'b0, 3, "R3 back to back", 1'b0);
    illegalCfg(1'b0, 1);
    illegalCfg(1'b0, 9);
    illegalCfg(1'b1, 5);
    illegalCfg(1'b1, 2);
    illegalCfg(1'b1, 12);
    midReset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule